// File: doc/BRIEF.md
# Transport Stream Input Capture

This block takes an MPEG transport stream and turns it into a filtered byte stream. The stream arrives either as whole bytes on a parallel bus or one bit at a time on a serial line. A data-valid strobe qualifies each input beat, and a packet-start strobe may accompany it. All inputs are sampled on the block clock. The block builds bytes, finds the packet boundaries and parses the first four header bytes. The 13-bit PID is taken from header bytes 1 and 2: the low five bits of byte 1 form PID bits 12:8, and byte 2 forms bits 7:0. The two scrambling-control bits are bits 7:6 of header byte 3.

Each packet is then kept or dropped. The decision uses a 32-entry PID table, an all-pass override and a null-packet filter. A kept packet may also be marked for descrambling, with an odd-key or even-key choice. Packet bytes pass through a four-byte delay line. The decision, made once header byte 3 is in, therefore travels with byte 0 when it leaves the block. Configuration comes in on static input pins, and table entries are written through a simple write strobe.

Top module: `ts_capture`

## Requirements
- R1: After reset, all outputs are 0 and every table entry is disabled. With all-pass off, no packet is then accepted.
- R2: Accepted bytes leave the block in arrival order. `out_valid` pulses once per byte. `out_sop` is high only on byte 0, and only together with `out_valid`.
- R3: `cfg_start_hi` and `cfg_valid_hi` set the active level of `ts_start` and `ts_valid`: 1 means active high, 0 means active low.
- R4: With `cfg_serial`=1, each active valid cycle delivers one bit on `ts_sdata`. With `cfg_msb_first`=1 the first bit of a byte is bit 7; with 0 it is bit 0. In sync mode the start strobe comes with the first bit of byte 0.
- R5: With `cfg_sync_mode`=1, a byte that comes with an active start strobe is byte 0. Bytes before the first start, and bytes after a packet has reached its length without a new start, are discarded.
- R6: With `cfg_sync_mode`=0, the start strobe is ignored. Packets are counted from reset, with a new byte 0 after every `cfg_pkt_len` valid bytes.
- R7: The packet length `cfg_pkt_len` is programmable from 4 to 255 bytes, including 188 and 204.
- R8: In sync mode, a start strobe that arrives before a packet is complete restarts the count at byte 0. If the interrupted packet had fewer than 4 bytes, none of its bytes is emitted.
- R9: With `cfg_drop_null`=1, packets with PID 0x1FFF are dropped whatever the other settings are. With 0, such packets are treated like any other.
- R10: With `cfg_all_pass`=0, a packet is accepted only if its PID equals an enabled table entry. Every accepted packet is then marked for descrambling.
- R11: With `cfg_all_pass`=1, every packet is accepted. It is marked for descrambling only when `cfg_cmp_pid`=1 and its PID matches an enabled entry.
- R12: For a packet marked for descrambling, `out_key_odd` is set when the scrambling-control bits equal `cfg_odd_code`. Otherwise `out_key_even` is set when they equal `cfg_even_code`. Odd wins when both codes are equal. A key flag is never set without `out_descr`.
- R13: A write with `tbl_we` stores `tbl_pid` and `tbl_en` in the entry chosen by the 5-bit `tbl_idx`, and replaces its previous contents. A disabled entry never matches.
- R14: `out_descr`, `out_key_odd` and `out_key_even` are high only on the byte that carries `out_sop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_start | input | 1 | Packet-start strobe |
| ts_valid | input | 1 | Data-valid strobe |
| ts_data | input | 8 | Parallel byte input |
| ts_sdata | input | 1 | Serial bit input |
| cfg_start_hi | input | 1 | Start strobe active level |
| cfg_valid_hi | input | 1 | Valid strobe active level |
| cfg_serial | input | 1 | 1 = serial input, 0 = parallel |
| cfg_msb_first | input | 1 | Serial bit order |
| cfg_sync_mode | input | 1 | 1 = start-strobe framing, 0 = valid-only framing |
| cfg_all_pass | input | 1 | Accept every packet |
| cfg_cmp_pid | input | 1 | Still compare PIDs under all-pass |
| cfg_drop_null | input | 1 | Drop PID 0x1FFF packets |
| cfg_pkt_len | input | 8 | Packet length in bytes |
| cfg_odd_code | input | 2 | Scrambling code selecting the odd key |
| cfg_even_code | input | 2 | Scrambling code selecting the even key |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 5 | Table entry index |
| tbl_pid | input | 13 | PID to store |
| tbl_en | input | 1 | Entry enable to store |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is byte 0 of a packet |
| out_descr | output | 1 | Packet marked for descrambling |
| out_key_odd | output | 1 | Odd key selected |
| out_key_even | output | 1 | Even key selected |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-bit length field and a 32-entry PID table. With these values it writes table index 31, runs packets of 4, 12, 16, 20, 188 and 204 bytes, and uses the real 13-bit PID space including the null PID. The short lengths keep the serial runs, where each byte takes eight cycles, within a small cycle budget. They also put the case where the next packet's byte 0 pushes out the previous packet's last bytes within reach.

// File: rtl/ts_capture.sv
`timescale 1ns/1ps
module ts_capture #(
  parameter int DW    = 8,
  parameter int LEN_W = 8,
  parameter int PID_W = 13,
  parameter int N_PID = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_start,
  input  logic             ts_valid,
  input  logic [DW-1:0]    ts_data,
  input  logic             ts_sdata,
  input  logic             cfg_start_hi,
  input  logic             cfg_valid_hi,
  input  logic             cfg_serial,
  input  logic             cfg_msb_first,
  input  logic             cfg_sync_mode,
  input  logic             cfg_all_pass,
  input  logic             cfg_cmp_pid,
  input  logic             cfg_drop_null,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [1:0]       cfg_odd_code,
  input  logic [1:0]       cfg_even_code,
  input  logic             tbl_we,
  input  logic [$clog2(N_PID)-1:0] tbl_idx,
  input  logic [PID_W-1:0] tbl_pid,
  input  logic             tbl_en,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_descr,
  output logic             out_key_odd,
  output logic             out_key_even
);
  localparam int BC_W  = $clog2(DW);
  localparam int HI_W  = PID_W - DW;
  localparam int DEPTH = 4;
  localparam logic [BC_W-1:0]  BIT_LAST = BC_W'(DW - 1);
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(DEPTH - 1);

  // strobe levels and serial byte assembly
  logic v_act, s_act, ser_restart;
  logic [DW-1:0] sh_reg, sh_next, byte_val;
  logic [BC_W-1:0] bit_cnt;
  logic sh_sos, byte_stb, byte_sos;

  assign v_act       = (ts_valid == cfg_valid_hi);
  assign s_act       = (ts_start == cfg_start_hi);
  assign ser_restart = v_act & s_act & cfg_sync_mode;
  assign sh_next     = cfg_msb_first ? {sh_reg[DW-2:0], ts_sdata} : {ts_sdata, sh_reg[DW-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_reg  <= '0;
      bit_cnt <= '0;
      sh_sos  <= 1'b0;
    end else if (cfg_serial && v_act) begin
      sh_reg <= sh_next;
      if (ser_restart) begin
        bit_cnt <= BC_W'(1);
        sh_sos  <= 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_LAST) sh_sos <= 1'b0;
      end
    end

  assign byte_stb = cfg_serial ? (v_act && bit_cnt == BIT_LAST && !ser_restart) : v_act;
  assign byte_val = cfg_serial ? sh_next : ts_data;
  assign byte_sos = cfg_serial ? sh_sos : s_act;

  // packet framing
  logic [LEN_W-1:0] cnt, idx;
  logic in_pkt, take, abort, last;

  always_comb begin
    take  = 1'b0;
    abort = 1'b0;
    idx   = cnt;
    if (byte_stb) begin
      if (!cfg_sync_mode) take = 1'b1;
      else if (byte_sos) begin
        take  = 1'b1;
        idx   = '0;
        abort = in_pkt;
      end else take = in_pkt;
    end
  end

  assign last = ({1'b0, idx} + 1'b1) == {1'b0, cfg_pkt_len};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      in_pkt <= 1'b0;
    end else if (take) begin
      cnt    <= last ? '0 : idx + 1'b1;
      in_pkt <= ~last;
    end

  // PID table
  logic [PID_W-1:0] ent_pid [N_PID];
  logic [N_PID-1:0] ent_en, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ent_en <= '0;
      for (int i = 0; i < N_PID; i++) ent_pid[i] <= '0;
    end else if (tbl_we) begin
      ent_pid[tbl_idx] <= tbl_pid;
      ent_en[tbl_idx]  <= tbl_en;
    end

  // header parse and packet decision
  logic [HI_W-1:0] hdr_hi;
  logic [DW-1:0]   hdr_lo;
  logic [PID_W-1:0] pid_now;
  logic [1:0] sc_now;
  logic at_dec, match, is_null, d_acc, d_descr, d_odd, d_even;
  logic pk_acc, pk_descr, pk_odd, pk_even;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hdr_hi <= '0;
      hdr_lo <= '0;
    end else if (take) begin
      if (idx == LEN_W'(1)) hdr_hi <= byte_val[HI_W-1:0];
      if (idx == LEN_W'(2)) hdr_lo <= byte_val;
    end

  assign at_dec  = take && idx == HDR_LAST;
  assign pid_now = {hdr_hi, hdr_lo};
  assign sc_now  = byte_val[DW-1 -: 2];

  for (genvar g = 0; g < N_PID; g++) begin : g_cmp
    assign hit[g] = ent_en[g] && (ent_pid[g] == pid_now);
  end

  assign match   = |hit;
  assign is_null = &pid_now;
  assign d_acc   = (cfg_all_pass | match) & ~(cfg_drop_null & is_null);
  assign d_descr = d_acc & match & (~cfg_all_pass | cfg_cmp_pid);
  assign d_odd   = d_descr & (sc_now == cfg_odd_code);
  assign d_even  = d_descr & (sc_now == cfg_even_code) & ~d_odd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pk_acc   <= 1'b0;
      pk_descr <= 1'b0;
      pk_odd   <= 1'b0;
      pk_even  <= 1'b0;
    end else if (at_dec) begin
      pk_acc   <= d_acc;
      pk_descr <= d_descr;
      pk_odd   <= d_odd;
      pk_even  <= d_even;
    end

  // four-byte delay line
  logic [DW-1:0] p_d [DEPTH];
  logic [DEPTH-1:0] p_sop, p_keep, p_pend;
  logic n_keep, emit;

  assign n_keep = at_dec ? d_acc : (idx > HDR_LAST) ? pk_acc : 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) p_d[i] <= '0;
      p_sop  <= '0;
      p_keep <= '0;
      p_pend <= '0;
    end else if (take) begin
      p_d[0]    <= byte_val;
      p_sop[0]  <= (idx == '0);
      p_keep[0] <= n_keep;
      p_pend[0] <= (idx < HDR_LAST);
      for (int i = 1; i < DEPTH; i++) begin
        p_d[i]    <= p_d[i-1];
        p_sop[i]  <= p_sop[i-1];
        p_keep[i] <= p_pend[i-1] ? (at_dec & d_acc) : p_keep[i-1];
        p_pend[i] <= p_pend[i-1] & ~abort & ~at_dec;
      end
    end

  assign emit = take & p_keep[DEPTH-1] & ~p_pend[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sop      <= 1'b0;
      out_descr    <= 1'b0;
      out_key_odd  <= 1'b0;
      out_key_even <= 1'b0;
    end else begin
      out_valid    <= emit;
      out_sop      <= emit & p_sop[DEPTH-1];
      out_descr    <= emit & p_sop[DEPTH-1] & pk_descr;
      out_key_odd  <= emit & p_sop[DEPTH-1] & pk_odd;
      out_key_even <= emit & p_sop[DEPTH-1] & pk_even;
      if (take) out_data <= p_d[DEPTH-1];
    end

  a_r14_flags_need_sop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_descr | out_key_odd | out_key_even) |-> out_sop);
  a_r12_key_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_key_odd, out_key_even}) <= 1);
  a_r12_key_needs_descr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_key_odd | out_key_even) |-> out_descr);
  a_r2_sop_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  a_r2_emit_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(byte_stb));
  a_r4_serial_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_serial && byte_stb) |=> !(cfg_serial && byte_stb));
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && abort) |=> (p_pend == 4'b0001));
endmodule

// File: tb/tb_ts_capture.sv
`timescale 1ns/1ps
module tb_ts_capture;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic ts_start = 1'b0, ts_valid = 1'b0, ts_sdata = 1'b0;
  logic [7:0] ts_data = '0;
  logic cfg_start_hi, cfg_valid_hi, cfg_serial, cfg_msb_first, cfg_sync_mode;
  logic cfg_all_pass, cfg_cmp_pid, cfg_drop_null;
  logic [7:0] cfg_pkt_len;
  logic [1:0] cfg_odd_code, cfg_even_code;
  logic tbl_we = 1'b0, tbl_en = 1'b0;
  logic [4:0] tbl_idx = '0;
  logic [12:0] tbl_pid = '0;
  logic out_valid, out_sop, out_descr, out_key_odd, out_key_even;
  logic [7:0] out_data;

  ts_capture dut (
    .clk(clk), .rst_n(rst_n), .ts_start(ts_start), .ts_valid(ts_valid),
    .ts_data(ts_data), .ts_sdata(ts_sdata), .cfg_start_hi(cfg_start_hi),
    .cfg_valid_hi(cfg_valid_hi), .cfg_serial(cfg_serial), .cfg_msb_first(cfg_msb_first),
    .cfg_sync_mode(cfg_sync_mode), .cfg_all_pass(cfg_all_pass), .cfg_cmp_pid(cfg_cmp_pid),
    .cfg_drop_null(cfg_drop_null), .cfg_pkt_len(cfg_pkt_len), .cfg_odd_code(cfg_odd_code),
    .cfg_even_code(cfg_even_code), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_pid(tbl_pid),
    .tbl_en(tbl_en), .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_descr(out_descr), .out_key_odd(out_key_odd), .out_key_even(out_key_even)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [11:0] exp_q[$];
  logic [12:0] m_pid [32];
  logic        m_en  [32];
  logic [11:0] got_w;
  assign got_w = {out_sop, out_descr, out_key_odd, out_key_even, out_data};

  task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected byte", {20'd0, got_w}, 32'd0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk(got_w == e, "byte {sop,descr,odd,even,data}", {20'd0, got_w}, {20'd0, e});
      end
    end

  function automatic logic [7:0] pbyte(input logic [12:0] pid, input logic [1:0] sc,
                                       input logic [7:0] seed, input int i);
    case (i)
      0: return 8'h47;
      1: return {3'b010, pid[12:8]};
      2: return pid[7:0];
      3: return {sc, 2'b01, seed[3:0]};
      default: return seed + 8'(i * 3);
    endcase
  endfunction

  function automatic logic [3:0] classify(input logic [12:0] pid, input logic [1:0] sc);
    logic hit, acc, ds, od, ev;
    hit = 1'b0;
    for (int i = 0; i < 32; i++) if (m_en[i] && m_pid[i] == pid) hit = 1'b1;
    acc = (cfg_all_pass || hit) && !(cfg_drop_null && pid == 13'h1FFF);
    ds  = acc && hit && (!cfg_all_pass || cfg_cmp_pid);
    od  = ds && sc == cfg_odd_code;
    ev  = ds && sc == cfg_even_code && !od;
    return {acc, ds, od, ev};
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      ts_valid = ~cfg_valid_hi;
      ts_start = ~cfg_start_hi;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input bit st);
    if (!cfg_serial) begin
      @(negedge clk);
      ts_data  = b;
      ts_valid = cfg_valid_hi;
      ts_start = st ? cfg_start_hi : ~cfg_start_hi;
    end else begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        ts_sdata = cfg_msb_first ? b[7-k] : b[k];
        ts_valid = cfg_valid_hi;
        ts_start = (st && k == 0) ? cfg_start_hi : ~cfg_start_hi;
      end
    end
  endtask

  task automatic send_pkt(input logic [12:0] pid, input logic [1:0] sc, input logic [7:0] seed,
                          input int nbytes, input int start_pos, input int gap);
    logic [3:0] cl;
    cl = classify(pid, sc);
    if (cl[3] && nbytes >= 4)
      for (int i = 0; i < nbytes; i++)
        exp_q.push_back({i == 0, (i == 0) & cl[2], (i == 0) & cl[1], (i == 0) & cl[0],
                         pbyte(pid, sc, seed, i)});
    for (int i = 0; i < nbytes; i++) begin
      put_byte(pbyte(pid, sc, seed, i), i == start_pos);
      if (gap > 0 && i % 7 == 3) idle(gap);
    end
    idle(1);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) put_byte(8'hE0 + 8'(i), i == 0);
    idle(4);
    chk(exp_q.size() == 0, "bytes still expected after flush", exp_q.size(), 0);
  endtask

  task automatic wr_tbl(input int idx, input logic [12:0] pid, input logic en);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 5'(idx); tbl_pid = pid; tbl_en = en;
    @(negedge clk);
    tbl_we = 1'b0;
    m_pid[idx] = pid;
    m_en[idx]  = en;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_start_hi = 1; cfg_valid_hi = 1; cfg_serial = 0; cfg_msb_first = 1; cfg_sync_mode = 1;
    cfg_all_pass = 0; cfg_cmp_pid = 0; cfg_drop_null = 0; cfg_pkt_len = 8'd188;
    cfg_odd_code = 2'd2; cfg_even_code = 2'd3;
    ts_valid = 0; ts_start = 0; ts_data = '0; ts_sdata = 0; tbl_we = 0;
    for (int i = 0; i < 32; i++) begin m_pid[i] = '0; m_en[i] = 1'b0; end
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    do_reset();
    chk({out_valid, out_sop, out_descr, out_key_odd, out_key_even, out_data} == '0,
        "outputs after reset", {out_valid, out_sop, out_descr, out_key_odd, out_key_even, out_data}, 0);
    send_pkt(13'h000, 2'd0, 8'h10, 188, 0, 0);
    flush();
  endtask

  task automatic t_parallel();
    cur_req = "R2 R10 R12 R13 R14";
    do_reset();
    wr_tbl(3, 13'h100, 1'b1);
    send_pkt(13'h100, 2'd2, 8'h20, 188, 0, 0);
    send_pkt(13'h200, 2'd2, 8'h30, 188, 0, 0);
    send_pkt(13'h100, 2'd3, 8'h40, 188, 0, 1);
    send_pkt(13'h100, 2'd0, 8'h50, 188, 0, 0);
    send_pkt(13'h100, 2'd1, 8'h60, 188, 0, 2);
    flush();
  endtask

  task automatic t_lengths();
    cur_req = "R7 R11";
    do_reset();
    cfg_pkt_len = 8'd204; cfg_all_pass = 1;
    wr_tbl(0, 13'h100, 1'b1);
    send_pkt(13'h100, 2'd2, 8'h11, 204, 0, 0);
    send_pkt(13'h333, 2'd3, 8'h22, 204, 0, 0);
    flush();
    do_reset();
    cfg_pkt_len = 8'd4; cfg_all_pass = 1;
    send_pkt(13'h010, 2'd0, 8'h33, 4, 0, 0);
    send_pkt(13'h011, 2'd1, 8'h44, 4, 0, 0);
    send_pkt(13'h012, 2'd2, 8'h55, 4, 0, 0);
    flush();
  endtask

  task automatic t_allpass_cmp();
    cur_req = "R11 R13";
    do_reset();
    cfg_all_pass = 1; cfg_cmp_pid = 1; cfg_pkt_len = 8'd20;
    wr_tbl(31, 13'h0ABC, 1'b1);
    send_pkt(13'h0ABC, 2'd2, 8'h01, 20, 0, 0);
    send_pkt(13'h0ABD, 2'd2, 8'h02, 20, 0, 0);
    send_pkt(13'h0ABC, 2'd3, 8'h03, 20, 0, 0);
    flush();
  endtask

  task automatic t_polarity();
    cur_req = "R3";
    for (int m = 0; m < 3; m++) begin
      do_reset();
      cfg_all_pass = 1; cfg_pkt_len = 8'd20;
      cfg_start_hi = (m == 2); cfg_valid_hi = (m == 1);
      ts_valid = ~cfg_valid_hi; ts_start = ~cfg_start_hi;
      idle(2);
      send_pkt(13'h077, 2'd0, 8'h70 + 8'(m), 20, 0, 2);
      send_pkt(13'h078, 2'd1, 8'h80 + 8'(m), 20, 0, 0);
      flush();
    end
  endtask

  task automatic t_serial();
    cur_req = "R4";
    for (int m = 0; m < 2; m++) begin
      do_reset();
      cfg_serial = 1; cfg_msb_first = (m == 0); cfg_all_pass = 1; cfg_pkt_len = 8'd12;
      send_pkt(13'h0C3, 2'd2, 8'h91, 12, 0, 0);
      send_pkt(13'h13C, 2'd1, 8'hA6, 12, 0, 1);
      flush();
    end
  endtask

  task automatic t_sync_discard();
    cur_req = "R5";
    do_reset();
    cfg_all_pass = 1; cfg_pkt_len = 8'd20;
    for (int i = 0; i < 5; i++) put_byte(8'hB0 + 8'(i), 1'b0);
    idle(1);
    send_pkt(13'h021, 2'd0, 8'h12, 20, 0, 0);
    for (int i = 0; i < 6; i++) put_byte(8'hC0 + 8'(i), 1'b0);
    idle(1);
    send_pkt(13'h022, 2'd0, 8'h34, 20, 0, 0);
    flush();
  endtask

  task automatic t_valid_mode();
    cur_req = "R6";
    do_reset();
    cfg_sync_mode = 0; cfg_all_pass = 1; cfg_pkt_len = 8'd16;
    send_pkt(13'h031, 2'd0, 8'h05, 16, 5, 0);
    send_pkt(13'h032, 2'd1, 8'h15, 16, -1, 1);
    send_pkt(13'h033, 2'd2, 8'h25, 16, 9, 0);
    flush();
  endtask

  task automatic t_restart();
    cur_req = "R8";
    do_reset();
    cfg_all_pass = 1; cfg_pkt_len = 8'd20;
    send_pkt(13'h041, 2'd0, 8'h61, 2, 0, 0);
    send_pkt(13'h042, 2'd0, 8'h62, 20, 0, 0);
    send_pkt(13'h043, 2'd0, 8'h63, 3, 0, 0);
    send_pkt(13'h044, 2'd0, 8'h64, 20, 0, 0);
    flush();
  endtask

  task automatic t_null();
    cur_req = "R9";
    do_reset();
    cfg_all_pass = 1; cfg_drop_null = 1; cfg_pkt_len = 8'd20;
    send_pkt(13'h1FFF, 2'd0, 8'h81, 20, 0, 0);
    send_pkt(13'h1FFE, 2'd0, 8'h82, 20, 0, 0);
    cfg_drop_null = 0;
    send_pkt(13'h1FFF, 2'd0, 8'h83, 20, 0, 0);
    cfg_all_pass = 0; cfg_drop_null = 1;
    wr_tbl(7, 13'h1FFF, 1'b1);
    send_pkt(13'h1FFF, 2'd2, 8'h84, 20, 0, 0);
    flush();
  endtask

  task automatic t_keys();
    cur_req = "R12 R13";
    do_reset();
    cfg_pkt_len = 8'd20; cfg_odd_code = 2'd1; cfg_even_code = 2'd1;
    wr_tbl(5, 13'h055, 1'b1);
    send_pkt(13'h055, 2'd1, 8'hD1, 20, 0, 0);
    cfg_even_code = 2'd2;
    send_pkt(13'h055, 2'd2, 8'hD2, 20, 0, 0);
    wr_tbl(5, 13'h055, 1'b0);
    send_pkt(13'h055, 2'd1, 8'hD3, 20, 0, 0);
    wr_tbl(5, 13'h066, 1'b1);
    send_pkt(13'h066, 2'd1, 8'hD4, 20, 0, 0);
    flush();
  endtask

  initial begin
    t_reset();
    t_parallel();
    t_lengths();
    t_allpass_cmp();
    t_polarity();
    t_serial();
    t_sync_discard();
    t_valid_mode();
    t_restart();
    t_null();
    t_keys();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: got hang expected completion", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule